// File: doc/BRIEF.md
# Upward-Growing Stack Pointer Sequencer

This block owns the 8-bit stack pointer of a small 8-bit processor core and turns stack commands into single-cycle accesses on a 256-byte internal RAM port. It handles four kinds of command. A one-byte push stores an operand. A one-byte pop returns a stored value to a destination register. A call stores a 16-bit return address as two bytes. A return reads two bytes back and rebuilds the program counter. An interrupt-return variant also emits a one-cycle release pulse, which lets the interrupt controller accept new requests at the level that was in service.

The stack grows toward higher addresses. A push increments the pointer first and then writes at the new pointer value. A pop reads at the current pointer and then decrements it. A command is taken in any cycle where `busy` is low. The RAM accesses run in the cycles that follow, and the results of a pop or a return appear one cycle after the last access. The RAM itself sits outside the block. Its read data is expected in the same cycle the address is driven.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x07, `busy` is low, and no write, pop result, PC load or release pulse is signalled.
- R2: A push (op code 1) raises the pointer by one and writes the operand byte at the raised pointer value.
- R3: A pop (op code 2) without the pointer as destination reads RAM at the current pointer, lowers the pointer by one, and presents the byte on `pop_data` with `pop_valid` high for exactly one cycle.
- R4: A pop with `cmd_to_sp` set leaves the pointer equal to the byte read, discarding the decrement, and does not raise `pop_valid`.
- R5: A call (op code 3) writes return-address bits 7:0 at pointer+1 and then bits 15:8 at pointer+2, leaving the pointer two higher.
- R6: A return (op code 4) reads PC bits 15:8 at the pointer and then PC bits 7:0 one below it, leaving the pointer two lower. It then presents the 16-bit value on `pc_value` with `pc_load` high for one cycle.
- R7: An interrupt return (op code 5) behaves as R6 and also raises `reti_release` for the same single cycle as `pc_load`. A plain return never raises it.
- R8: `busy` stays high for one cycle after a push or pop and for two cycles after a call or return. Commands presented while `busy` is high are ignored, and op codes 0, 6 and 7 start nothing.
- R9: The pointer wraps modulo 256 in both directions: a push from 0xFF writes at 0x00, and a pop from 0x00 leaves 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 none, 1 push, 2 pop, 3 call, 4 return, 5 interrupt return) |
| cmd_byte | input | 8 | Operand byte for a push |
| cmd_to_sp | input | 1 | Pop destination is the stack pointer |
| cmd_ret_addr | input | 16 | Return address stored by a call |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data for `ram_addr` |
| busy | output | 1 | Sequence in progress; commands ignored |
| sp | output | 8 | Current stack pointer |
| pop_valid | output | 1 | One-cycle strobe for a popped byte |
| pop_data | output | 8 | Popped byte |
| pc_load | output | 1 | One-cycle strobe to load the program counter |
| pc_value | output | 16 | Rebuilt program counter |
| reti_release | output | 1 | One-cycle release pulse on interrupt return |

## Verification
A fixed series of pushes, pops, calls and returns is applied from the reset pointer. It shows that write order and read order mirror each other: a return must rebuild the same address a call stored, and a pop must return the last push. Pops into the pointer are driven with values far from the current pointer, which separates a load from a decrement. Pushing from 0xFF and popping from 0x00 exposes a missing wrap. Commands held high through a call's busy window, and an idle op code, show whether the sequencer starts work it should refuse.

// File: rtl/stack_ptr_pkg.sv
package stack_ptr_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_RETI = 3'd5
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2
  } stk_state_e;

  function automatic logic op_is_legal(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

  function automatic logic op_is_double(input stk_op_e op);
    return (op == OP_CALL) || (op == OP_RET) || (op == OP_RETI);
  endfunction

endpackage

// File: rtl/stk_sequencer.sv
module stk_sequencer
  import stack_ptr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              cmd_to_sp,
  input  logic [PC_W-1:0]   cmd_ret_addr,
  output logic              busy,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_byte,
  output logic              rd_req,
  output logic              sp_dec,
  output logic              sp_load,
  output logic              deliver_pop,
  output logic              cap_hi,
  output logic              finish_ret,
  output logic              is_reti
);

  stk_state_e        state_q, state_d;
  stk_op_e           op_q;
  logic [DATA_W-1:0] byte_q;
  logic              to_sp_q;
  logic [PC_W-1:0]   ret_q;
  logic              start;

  assign start = (state_q == ST_IDLE) && cmd_valid && op_is_legal(cmd_op);
  assign busy  = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_ONE;
      ST_ONE:  state_d = op_is_double(op_q) ? ST_TWO : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wr_req      = 1'b0;
    wr_byte     = byte_q;
    rd_req      = 1'b0;
    sp_dec      = 1'b0;
    sp_load     = 1'b0;
    deliver_pop = 1'b0;
    cap_hi      = 1'b0;
    finish_ret  = 1'b0;
    is_reti     = (op_q == OP_RETI);
    if (state_q == ST_ONE) begin
      case (op_q)
        OP_PUSH: wr_req = 1'b1;
        OP_POP: begin
          rd_req      = 1'b1;
          sp_load     = to_sp_q;
          sp_dec      = !to_sp_q;
          deliver_pop = !to_sp_q;
        end
        OP_CALL: begin
          wr_req  = 1'b1;
          wr_byte = ret_q[DATA_W-1:0];
        end
        OP_RET, OP_RETI: begin
          rd_req = 1'b1;
          sp_dec = 1'b1;
          cap_hi = 1'b1;
        end
        default: ;
      endcase
    end else if (state_q == ST_TWO) begin
      case (op_q)
        OP_CALL: begin
          wr_req  = 1'b1;
          wr_byte = ret_q[PC_W-1:DATA_W];
        end
        OP_RET, OP_RETI: begin
          rd_req     = 1'b1;
          sp_dec     = 1'b1;
          finish_ret = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      byte_q  <= '0;
      to_sp_q <= 1'b0;
      ret_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start) begin
        op_q    <= stk_op_e'(cmd_op);
        byte_q  <= cmd_byte;
        to_sp_q <= cmd_to_sp;
        ret_q   <= cmd_ret_addr;
      end
    end
  end

  // R8: a two-byte command keeps the sequencer busy for exactly two cycles
  assert_double_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_is_double(stk_op_e'(cmd_op))) |=> busy ##1 busy ##1 !busy);

  // R8: a one-byte command keeps it busy for exactly one cycle
  assert_single_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !op_is_double(stk_op_e'(cmd_op))) |=> busy ##1 !busy);

endmodule

// File: rtl/stk_pointer.sv
module stk_pointer #(
  parameter int             AW       = 8,
  parameter logic [AW-1:0]  RESET_SP = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] sp
);

  localparam logic [AW-1:0] STEP = AW'(1);

  logic [AW-1:0] sp_q, sp_d;
  logic          sp_en;

  assign sp_en = inc || dec || load;

  always_comb begin
    sp_d = sp_q;
    if (load)     sp_d = load_val;
    else if (inc) sp_d = sp_q + STEP;
    else if (dec) sp_d = sp_q - STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= RESET_SP;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;

  // R9: the pointer holds still when no update is requested
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_en |=> $stable(sp_q));

endmodule

// File: rtl/stk_ram_port.sv
module stk_ram_port #(
  parameter int AW     = 8,
  parameter int DATA_W = 8
) (
  input  logic [AW-1:0]     sp,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [AW-1:0]     ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we
);

  localparam logic [AW-1:0] STEP = AW'(1);

  always_comb begin
    ram_addr  = wr_req ? (sp + STEP) : sp;
    ram_wdata = wr_req ? wr_byte : '0;
    ram_we    = wr_req;
  end

endmodule

// File: rtl/stk_result.sv
module stk_result #(
  parameter int DATA_W = 8,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rd_byte,
  input  logic              deliver_pop,
  input  logic              cap_hi,
  input  logic              finish_ret,
  input  logic              is_reti,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_value,
  output logic              reti_release
);

  localparam int HI_W = PC_W - DATA_W;

  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q         <= '0;
      pop_valid    <= 1'b0;
      pop_data     <= '0;
      pc_load      <= 1'b0;
      pc_value     <= '0;
      reti_release <= 1'b0;
    end else begin
      pop_valid    <= deliver_pop;
      pc_load      <= finish_ret;
      reti_release <= finish_ret && is_reti;
      if (cap_hi)      hi_q     <= HI_W'(rd_byte);
      if (deliver_pop) pop_data <= rd_byte;
      if (finish_ret)  pc_value <= {hi_q, rd_byte};
    end
  end

  // R7: the release pulse only accompanies a program counter load
  assert_release_with_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reti_release |-> pc_load);

  // R3: pop result and PC load never coincide
  assert_pop_not_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> !pc_load);

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stack_ptr_pkg::*;
#(
  parameter int            DATA_W   = 8,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] RESET_SP = 8'h07
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [DATA_W-1:0]   cmd_byte,
  input  logic                cmd_to_sp,
  input  logic [2*DATA_W-1:0] cmd_ret_addr,
  output logic [AW-1:0]       ram_addr,
  output logic [DATA_W-1:0]   ram_wdata,
  output logic                ram_we,
  input  logic [DATA_W-1:0]   ram_rdata,
  output logic                busy,
  output logic [AW-1:0]       sp,
  output logic                pop_valid,
  output logic [DATA_W-1:0]   pop_data,
  output logic                pc_load,
  output logic [2*DATA_W-1:0] pc_value,
  output logic                reti_release
);

  localparam int PC_W = 2 * DATA_W;

  logic              wr_req, rd_req, sp_dec, sp_load;
  logic              deliver_pop, cap_hi, finish_ret, is_reti;
  logic [DATA_W-1:0] wr_byte;

  stk_sequencer #(.DATA_W(DATA_W), .PC_W(PC_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_byte     (cmd_byte),
    .cmd_to_sp    (cmd_to_sp),
    .cmd_ret_addr (cmd_ret_addr),
    .busy         (busy),
    .wr_req       (wr_req),
    .wr_byte      (wr_byte),
    .rd_req       (rd_req),
    .sp_dec       (sp_dec),
    .sp_load      (sp_load),
    .deliver_pop  (deliver_pop),
    .cap_hi       (cap_hi),
    .finish_ret   (finish_ret),
    .is_reti      (is_reti)
  );

  stk_pointer #(.AW(AW), .RESET_SP(RESET_SP)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (wr_req),
    .dec      (sp_dec),
    .load     (sp_load),
    .load_val (AW'(ram_rdata)),
    .sp       (sp)
  );

  stk_ram_port #(.AW(AW), .DATA_W(DATA_W)) u_port (
    .sp        (sp),
    .wr_req    (wr_req),
    .wr_byte   (wr_byte),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we)
  );

  stk_result #(.DATA_W(DATA_W), .PC_W(PC_W)) u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_byte      (ram_rdata),
    .deliver_pop  (deliver_pop),
    .cap_hi       (cap_hi),
    .finish_ret   (finish_ret),
    .is_reti      (is_reti),
    .pop_valid    (pop_valid),
    .pop_data     (pop_data),
    .pc_load      (pc_load),
    .pc_value     (pc_value),
    .reti_release (reti_release)
  );

  // R2: every write lands at the address the pointer moves to
  assert_push_preinc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (sp == $past(ram_addr)));

  // R3: a decrementing read leaves the pointer one below the address read
  assert_pop_postdec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !sp_load) |=> (sp == $past(ram_addr) - AW'(1)));

  // R4: a pop into the pointer leaves the byte read in the pointer
  assert_pop_to_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> (sp == AW'($past(ram_rdata))) && !pop_valid);

  // R6: a PC load follows a busy cycle
  assert_pc_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(busy));

  // R8: no RAM write while idle
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_we);

endmodule

// File: tb/stack_ptr_unit_test.sv
module stack_ptr_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  // fields: op[51:49] byte[48:41] to_sp[40] ret[39:24] exp_sp[23:16] exp_out[15:0]
  localparam logic [51:0] VEC [NV] = '{
    {3'd1, 8'hA5, 1'b0, 16'h0000, 8'h08, 16'h00A5},
    {3'd1, 8'h3C, 1'b0, 16'h0000, 8'h09, 16'h003C},
    {3'd2, 8'h00, 1'b0, 16'h0000, 8'h08, 16'h003C},
    {3'd3, 8'h00, 1'b0, 16'h0125, 8'h0A, 16'h0125},
    {3'd4, 8'h00, 1'b0, 16'h0000, 8'h08, 16'h0125},
    {3'd2, 8'h00, 1'b0, 16'h0000, 8'h07, 16'h00A5},
    {3'd3, 8'h00, 1'b0, 16'hBEEF, 8'h09, 16'hBEEF},
    {3'd5, 8'h00, 1'b0, 16'h0000, 8'h07, 16'hBEEF}
  };

  logic        clk, rst_n;
  logic        cmd_valid, cmd_to_sp;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic [15:0] cmd_ret_addr;
  logic [7:0]  ram_addr, ram_wdata, ram_rdata;
  logic        ram_we, busy, pop_valid, pc_load, reti_release;
  logic [7:0]  sp, pop_data;
  logic [15:0] pc_value;
  logic [7:0]  mem [256];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  stack_ptr_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_to_sp(cmd_to_sp), .cmd_ret_addr(cmd_ret_addr),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .busy(busy), .sp(sp), .pop_valid(pop_valid),
    .pop_data(pop_data), .pc_load(pc_load), .pc_value(pc_value),
    .reti_release(reti_release)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] b, input logic to_sp,
                         input logic [15:0] ra, output int bcyc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_byte = b; cmd_to_sp = to_sp; cmd_ret_addr = ra;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    bcyc = 0;
    while (busy) begin
      bcyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int bc;
    logic [7:0] s0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    cmd_valid = 0; cmd_op = 0; cmd_byte = 0; cmd_to_sp = 0; cmd_ret_addr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(sp == 8'h07, "R1", "reset sp", sp, 8'h07);
    chk(!busy && !ram_we && !pop_valid && !pc_load && !reti_release, "R1", "idle outputs",
        {busy, ram_we, pop_valid, pc_load, reti_release}, 0);

    // table of commands
    for (int v = 0; v < NV; v++) begin
      logic [2:0]  op;
      logic [7:0]  es;
      logic [15:0] eo;
      op = VEC[v][51:49]; es = VEC[v][23:16]; eo = VEC[v][15:0];
      run_cmd(op, VEC[v][48:41], VEC[v][40], VEC[v][39:24], bc);
      case (op)
        3'd1: begin
          chk(sp == es, "R2", "push sp", sp, es);
          chk(mem[es] == eo[7:0], "R2", "push data", mem[es], eo[7:0]);
          chk(bc == 1, "R8", "push busy cycles", bc, 1);
        end
        3'd2: begin
          chk(sp == es, "R3", "pop sp", sp, es);
          chk(pop_valid && pop_data == eo[7:0], "R3", "pop data", {pop_valid, pop_data}, {1'b1, eo[7:0]});
          @(negedge clk);
          chk(!pop_valid, "R3", "pop strobe one cycle", pop_valid, 0);
        end
        3'd3: begin
          chk(sp == es, "R5", "call sp", sp, es);
          chk(mem[es - 8'd1] == eo[7:0], "R5", "call low byte", mem[es - 8'd1], eo[7:0]);
          chk(mem[es] == eo[15:8], "R5", "call high byte", mem[es], eo[15:8]);
          chk(bc == 2, "R8", "call busy cycles", bc, 2);
        end
        default: begin
          chk(sp == es, "R6", "return sp", sp, es);
          chk(pc_load && pc_value == eo, "R6", "return pc", {pc_load, pc_value}, {1'b1, eo});
          chk(reti_release == (op == 3'd5), "R7", "release pulse", reti_release, (op == 3'd5));
          chk(bc == 2, "R8", "return busy cycles", bc, 2);
          @(negedge clk);
          chk(!pc_load && !reti_release, "R7", "pulses one cycle", {pc_load, reti_release}, 0);
        end
      endcase
    end

    // R4 pop into the pointer
    run_cmd(3'd1, 8'h20, 1'b0, 16'h0, bc);
    run_cmd(3'd2, 8'h00, 1'b1, 16'h0, bc);
    chk(sp == 8'h20, "R4", "pop to sp value", sp, 8'h20);
    chk(!pop_valid, "R4", "no pop strobe", pop_valid, 0);

    // R9 wrap upward and downward
    run_cmd(3'd1, 8'hFF, 1'b0, 16'h0, bc);
    run_cmd(3'd2, 8'h00, 1'b1, 16'h0, bc);
    chk(sp == 8'hFF, "R4", "pointer loaded 0xFF", sp, 8'hFF);
    run_cmd(3'd1, 8'h11, 1'b0, 16'h0, bc);
    chk(sp == 8'h00 && mem[0] == 8'h11, "R9", "push wraps", {sp, mem[0]}, {8'h00, 8'h11});
    run_cmd(3'd2, 8'h00, 1'b0, 16'h0, bc);
    chk(sp == 8'hFF && pop_data == 8'h11, "R9", "pop wraps", {sp, pop_data}, {8'hFF, 8'h11});

    // R8 commands ignored while busy
    s0 = sp;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_ret_addr = 16'h4321; cmd_to_sp = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmd_op = 3'd1; cmd_byte = 8'h77;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(sp == s0 + 8'd2, "R8", "busy ignores push", sp, s0 + 8'd2);
    chk(mem[8'h00] == 8'h21 && mem[8'h01] == 8'h43, "R5", "call across wrap",
        {mem[8'h00], mem[8'h01]}, 16'h2143);
    chk(mem[8'h02] != 8'h77, "R8", "ignored push wrote nothing", mem[8'h02], 0);
    @(negedge clk);
    chk(!busy && sp == s0 + 8'd2, "R8", "still idle", {busy, sp}, {1'b0, s0 + 8'd2});

    // R8 op code 0 and 6 start nothing
    s0 = sp;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0;
    @(negedge clk);
    chk(!busy && sp == s0, "R8", "code 0 idle", {busy, sp}, {1'b0, s0});
    cmd_op = 3'd6;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!busy && sp == s0, "R8", "code 6 idle", {busy, sp}, {1'b0, s0});

    // R1 reset mid-stream
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp == 8'h07 && !busy, "R1", "second reset", {busy, sp}, {1'b0, 8'h07});

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule